// File: doc/BRIEF.md
# Quadrant Memory Chip-Select Decoder

This block stands between a processor's physical address bus and a set of external static memory devices. It cuts the address space into four equal quadrants, picked by the two highest address bits of each request. Every quadrant has its own bank setting. That setting decides which of three active-low chip selects fires and which of two active-low read/write strobe pairs is driven, if any. It can also block writes to the quadrant, and it can flip address bits 19, 18 and 16 on their way to the memory. All other address bits reach the memory unchanged. The quadrant is always taken from the address as it arrives, before any bit is flipped. Two quadrants with the same setting make one 512 KB device appear across both.

A memory access enters through a valid/ready request channel that carries the address and a write flag. `req_ready` is high only while no access is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After `req_valid` rises, the requester must hold it and keep the address and write flag stable until the request is taken.

Each access then runs a fixed sequence:

- A setup clock, with the chip select asserted and, for a read, the output enable asserted.
- `STROBE_CYC` clocks with the write enable asserted, for a write.
- A hold clock, with the chip select still asserted and the write enable released.

After the hold clock all strobes go high and the block is ready for the next request. The bank settings are loaded through a small register port. A write to that port while an access is running has no effect on that access. It applies to later ones.

Top module: `mem_qd_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 for quadrant 0 (chip select 0, strobe pair 0, no inversion) and 0x03 for quadrants 1 to 3 (no chip select). All of `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, and `req_ready` is high.
- R2: A write with `cfg_we`=1 stores `cfg_wdata[6:0]` into the quadrant named by `cfg_addr`. `cfg_rdata` shows the register of the quadrant named by `cfg_addr`, and its bit 7 always reads 0.
- R3: For an access, the quadrant is `req_addr[19:18]` as received, whatever the inversion bits are. Bits[1:0] of that quadrant's register are 0, 1 or 2, and they drive `mem_cs_n` bit 0, 1 or 2 low, one at a time.
- R4: When bits[1:0] equal 3, no chip select, output enable or write enable goes low, and the access still finishes and returns `req_ready` high.
- R5: In a read, `mem_oe_n` bit k goes low for all `STROBE_CYC`+2 clocks of the access, where k is bit 2 of the register. `mem_we_n` stays high throughout.
- R6: In a write, `mem_we_n` bit k goes low for exactly `STROBE_CYC` clocks, where k is bit 2 of the register. That window starts one clock after the chip select goes low and ends one clock before it goes high. `mem_oe_n` stays high.
- R7: When bit 3 of the register is 1, a write still asserts the chip select for the full access, but `mem_we_n` stays high.
- R8: `mem_addr` equals `req_addr` with bit 18 inverted when register bit 4 is set, bit 19 inverted when bit 5 is set, and bit 16 inverted when bit 6 is set. It is held for the whole access.
- R9: `req_ready` is low from the clock edge that takes a request until the access ends, `STROBE_CYC`+2 clocks later. A request is taken only when `req_valid` and `req_ready` are both high.
- R10: The register contents are captured when the request is taken. A register write during an access changes only later accesses.
- R11: Whenever no access is in progress, all chip selects, output enables and write enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_addr | input | 2 | Quadrant whose register is written or read |
| cfg_wdata | input | 8 | Bank register write data (bit 7 ignored) |
| cfg_rdata | output | 8 | Bank register read data for `cfg_addr` |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_addr | input | 20 | Physical address of the request |
| mem_addr | output | 20 | Address to memory, with per-quadrant inversions |
| mem_cs_n | output | 3 | Active-low chip selects |
| mem_oe_n | output | 2 | Active-low output enables, one per strobe pair |
| mem_we_n | output | 2 | Active-low write enables, one per strobe pair |

## Verification
The bench builds the block with a 20-bit address and `STROBE_CYC` raised from its default of 2 to 3. With a wider write window, the bench can observe a middle strobe clock that is neither the first nor the last. It can also drop a register write into the middle of an access and show that the running access ignores it. The 20-bit address keeps the flipped bits at 19, 18 and 16, so an address in the top quadrant shows that the quadrant is decoded before inversion.

// File: rtl/mem_qd_pkg.sv
package mem_qd_pkg;
  localparam int unsigned QSEL_W = 2;
  localparam int unsigned NQ     = 1 << QSEL_W;
  localparam int unsigned NUM_CS = 3;
  localparam int unsigned NUM_PR = 2;
  localparam int unsigned CFG_W  = 7;
  localparam int unsigned REG_W  = 8;

  typedef struct packed {
    logic       inv16;
    logic       inv19;
    logic       inv18;
    logic       wprot;
    logic       pair;
    logic [1:0] cs_sel;
  } bank_cfg_t;

  localparam logic [CFG_W-1:0] RST_Q0   = 7'h00;
  localparam logic [CFG_W-1:0] RST_QOTH = 7'h03;
  localparam logic [1:0]       SEL_NONE = 2'd3;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mem_qd_bankregs.sv
module mem_qd_bankregs
  import mem_qd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [QSEL_W-1:0]            wr_sel,
  input  logic [CFG_W-1:0]             wr_data,
  output logic [NQ-1:0][CFG_W-1:0]     banks
);
  for (genvar q = 0; q < NQ; q++) begin : g_bank
    localparam logic [CFG_W-1:0] RVAL = (q == 0) ? RST_Q0 : RST_QOTH;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        banks[q] <= RVAL;
      end else if (wr_en && (wr_sel == QSEL_W'(q))) begin
        banks[q] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mem_qd_route.sv
module mem_qd_route
  import mem_qd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  bank_cfg_t           cfg,
  input  logic                is_write,
  input  logic [ADDR_W-1:0]   addr_in,
  output logic [NUM_CS-1:0]   cs_n,
  output logic [NUM_PR-1:0]   oe_n,
  output logic [NUM_PR-1:0]   we_n,
  output logic [ADDR_W-1:0]   addr_out
);
  localparam int unsigned B19 = ADDR_W - 1;
  localparam int unsigned B18 = ADDR_W - 2;
  localparam int unsigned B16 = ADDR_W - 4;

  logic device_on;
  assign device_on = (cfg.cs_sel != SEL_NONE);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_n[c] = !(cfg.cs_sel == 2'(c));
  end

  for (genvar p = 0; p < NUM_PR; p++) begin : g_pair
    logic this_pair;
    assign this_pair = device_on && (cfg.pair == 1'(p));
    assign oe_n[p]   = !(this_pair && !is_write);
    assign we_n[p]   = !(this_pair && is_write && !cfg.wprot);
  end

  always_comb begin
    addr_out      = addr_in;
    addr_out[B19] = addr_in[B19] ^ cfg.inv19;
    addr_out[B18] = addr_in[B18] ^ cfg.inv18;
    addr_out[B16] = addr_in[B16] ^ cfg.inv16;
  end
endmodule

// File: rtl/mem_qd_seq.sv
module mem_qd_seq
  import mem_qd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [NUM_CS-1:0]   rt_cs_n,
  input  logic [NUM_PR-1:0]   rt_oe_n,
  input  logic [NUM_PR-1:0]   rt_we_n,
  input  logic [ADDR_W-1:0]   rt_addr,
  output logic [NUM_CS-1:0]   cs_n,
  output logic [NUM_PR-1:0]   oe_n,
  output logic [NUM_PR-1:0]   we_n,
  output logic [ADDR_W-1:0]   mem_addr
);
  localparam int unsigned CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

  seq_state_t          state;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_PR-1:0]   we_pend;

  assign req_ready = (state == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      we_pend  <= '1;
      cs_n     <= '1;
      oe_n     <= '1;
      we_n     <= '1;
      mem_addr <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            cs_n     <= rt_cs_n;
            oe_n     <= rt_oe_n;
            we_pend  <= rt_we_n;
            mem_addr <= rt_addr;
            state    <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          we_n  <= we_pend;
          cnt   <= CNT_LOAD;
          state <= SQ_STROBE;
        end
        SQ_STROBE: begin
          if (cnt == '0) begin
            we_n  <= '1;
            state <= SQ_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_HOLD: begin
          cs_n  <= '1;
          oe_n  <= '1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_qd_top.sv
module mem_qd_top
  import mem_qd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2:0]          mem_cs_n,
  output logic [1:0]          mem_oe_n,
  output logic [1:0]          mem_we_n
);
  localparam int unsigned QHI = ADDR_W - 1;
  localparam int unsigned QLO = ADDR_W - QSEL_W;

  logic [NQ-1:0][CFG_W-1:0] banks;
  bank_cfg_t                cur_cfg;
  logic [NUM_CS-1:0]        rt_cs_n;
  logic [NUM_PR-1:0]        rt_oe_n;
  logic [NUM_PR-1:0]        rt_we_n;
  logic [ADDR_W-1:0]        rt_addr;

  mem_qd_bankregs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_addr),
    .wr_data (cfg_wdata[CFG_W-1:0]),
    .banks   (banks)
  );

  assign cfg_rdata = {1'b0, banks[cfg_addr]};
  assign cur_cfg   = bank_cfg_t'(banks[req_addr[QHI:QLO]]);

  mem_qd_route #(.ADDR_W(ADDR_W)) u_route (
    .cfg      (cur_cfg),
    .is_write (req_write),
    .addr_in  (req_addr),
    .cs_n     (rt_cs_n),
    .oe_n     (rt_oe_n),
    .we_n     (rt_we_n),
    .addr_out (rt_addr)
  );

  mem_qd_seq #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rt_cs_n   (rt_cs_n),
    .rt_oe_n   (rt_oe_n),
    .rt_we_n   (rt_we_n),
    .rt_addr   (rt_addr),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .mem_addr  (mem_addr)
  );
endmodule

// File: rtl/mem_qd_chk.sv
module mem_qd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] cfg_rdata,
  input logic [2:0] mem_cs_n,
  input logic [1:0] mem_oe_n,
  input logic [1:0] mem_we_n
);
  // R11
  idle_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == 3'b111 && mem_oe_n == 2'b11 && mem_we_n == 2'b11));

  // R3
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R6
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != 2'b11) |-> (mem_cs_n != 3'b111 && $past(mem_cs_n) != 3'b111));

  // R6
  we_off_before_cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&mem_cs_n) |-> $past(&mem_we_n));

  // R5
  oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n != 2'b11) |-> (mem_we_n == 2'b11));

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  rsvd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0);
endmodule

bind mem_qd_top mem_qd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_rdata (cfg_rdata),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/mem_qd_top_tb_top.sv
module mem_qd_top_tb_top;
  localparam int unsigned AW = 20;
  localparam int unsigned SC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [2:0]    mem_cs_n;
  logic [1:0]    mem_oe_n;
  logic [1:0]    mem_we_n;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  mem_qd_top #(.ADDR_W(AW), .STROBE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic cfg_write(input logic [1:0] q, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = q; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input string tag, input logic [1:0] q, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = q;
    #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  // One full access with per-phase checks; optional register write during setup.
  task automatic run_access(input string tag, input logic [AW-1:0] a, input logic wr,
                            input logic [2:0] e_cs, input logic [1:0] e_oe,
                            input logic [1:0] e_we, input logic [AW-1:0] e_addr,
                            input bit mid_wr, input logic [1:0] mid_q,
                            input logic [7:0] mid_d);
    @(negedge clk);
    check({tag, " R9 ready before"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R3 cs setup"}, 32'(mem_cs_n), 32'(e_cs));
    check({tag, " R5 oe setup"}, 32'(mem_oe_n), 32'(e_oe));
    check({tag, " R6 we off in setup"}, 32'(mem_we_n), 32'd3);
    check({tag, " R8 addr"}, 32'(mem_addr), 32'(e_addr));
    check({tag, " R9 busy"}, 32'(req_ready), 32'd0);
    if (mid_wr) begin
      cfg_we = 1'b1; cfg_addr = mid_q; cfg_wdata = mid_d;
    end
    for (int k = 0; k < SC; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      check({tag, " R6 we window"}, 32'(mem_we_n), 32'(e_we));
      check({tag, " R10 cs held"}, 32'(mem_cs_n), 32'(e_cs));
      check({tag, " R5 oe held"}, 32'(mem_oe_n), 32'(e_oe));
      check({tag, " R8 addr held"}, 32'(mem_addr), 32'(e_addr));
    end
    @(negedge clk);
    check({tag, " R6 we off in hold"}, 32'(mem_we_n), 32'd3);
    check({tag, " R6 cs in hold"}, 32'(mem_cs_n), 32'(e_cs));
    check({tag, " R9 busy hold"}, 32'(req_ready), 32'd0);
    @(negedge clk);
    check({tag, " R11 cs idle"}, 32'(mem_cs_n), 32'd7);
    check({tag, " R11 oe idle"}, 32'(mem_oe_n), 32'd3);
    check({tag, " R11 we idle"}, 32'(mem_we_n), 32'd3);
    check({tag, " R9 ready after"}, 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    check("R1 cs", 32'(mem_cs_n), 32'd7);
    check("R1 oe", 32'(mem_oe_n), 32'd3);
    check("R1 we", 32'(mem_we_n), 32'd3);
    check("R1 ready", 32'(req_ready), 32'd1);
    cfg_check("R1 q0", 2'd0, 8'h00);
    cfg_check("R1 q1", 2'd1, 8'h03);
    cfg_check("R1 q2", 2'd2, 8'h03);
    cfg_check("R1 q3", 2'd3, 8'h03);
  endtask

  task automatic t_regs();
    cfg_write(2'd2, 8'hFF);
    cfg_check("R2 bit7 reads 0", 2'd2, 8'h7F);
    cfg_write(2'd2, 8'h83);
    cfg_check("R2 rewrite", 2'd2, 8'h03);
    cfg_check("R2 neighbour untouched", 2'd1, 8'h03);
  endtask

  task automatic t_default_read();
    run_access("R3 q0 read", 20'h01234, 1'b0, 3'b110, 2'b10, 2'b11, 20'h01234, 0, 2'd0, 8'h0);
  endtask

  task automatic t_none();
    run_access("R4 no device", 20'h80000, 1'b1, 3'b111, 2'b11, 2'b11, 20'h80000, 0, 2'd0, 8'h0);
    run_access("R4 no device rd", 20'h8FFFF, 1'b0, 3'b111, 2'b11, 2'b11, 20'h8FFFF, 0, 2'd0, 8'h0);
  endtask

  task automatic t_write_pair1();
    cfg_write(2'd1, 8'h05);
    run_access("R6 q1 write", 20'h4ABCD, 1'b1, 3'b101, 2'b11, 2'b01, 20'h4ABCD, 0, 2'd0, 8'h0);
    run_access("R5 q1 read", 20'h4ABCD, 1'b0, 3'b101, 2'b01, 2'b11, 20'h4ABCD, 0, 2'd0, 8'h0);
  endtask

  task automatic t_wprot();
    cfg_write(2'd1, 8'h0D);
    run_access("R7 protected", 20'h40010, 1'b1, 3'b101, 2'b11, 2'b11, 20'h40010, 0, 2'd0, 8'h0);
  endtask

  task automatic t_invert();
    cfg_write(2'd3, 8'h72);
    run_access("R8 invert", 20'hC5555, 1'b0, 3'b011, 2'b10, 2'b11, 20'h15555, 0, 2'd0, 8'h0);
    cfg_write(2'd3, 8'h12);
    run_access("R8 inv18 wr", 20'hF0F0F, 1'b1, 3'b011, 2'b11, 2'b10, 20'hB0F0F, 0, 2'd0, 8'h0);
  endtask

  task automatic t_span();
    cfg_write(2'd1, 8'h00);
    run_access("R3 span lo", 20'h3FFFF, 1'b1, 3'b110, 2'b11, 2'b10, 20'h3FFFF, 0, 2'd0, 8'h0);
    run_access("R3 span hi", 20'h7FFFF, 1'b1, 3'b110, 2'b11, 2'b10, 20'h7FFFF, 0, 2'd0, 8'h0);
  endtask

  task automatic t_midwrite();
    run_access("R10 old cfg", 20'h00100, 1'b1, 3'b110, 2'b11, 2'b10, 20'h00100, 1, 2'd0, 8'h06);
    cfg_check("R10 reg updated", 2'd0, 8'h06);
    run_access("R10 new cfg", 20'h00100, 1'b1, 3'b011, 2'b11, 2'b01, 20'h00100, 0, 2'd0, 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_default_read();
    t_none();
    t_write_pair1();
    t_wprot();
    t_invert();
    t_span();
    t_midwrite();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end
endmodule